// File: doc/BRIEF.md
# Triggered SPI Command Engine

This block is a half-duplex SPI master that runs one complete command each time software triggers it. Software first loads a command byte, a send length, a receive length, a chip-select number and the outgoing payload into a byte-wide register space. The payload goes into a shared data buffer. A single trigger bit then starts the command. The engine lowers the chosen chip select and sends the command byte. It then sends the payload bytes that the buffer's internal pointer walks over, and then clocks in the requested number of reply bytes.

Reply bytes are written back into the same buffer. They land at the pointer position where the payload ended, so after a pointer reset they start at buffer index equal to the send length. Software polls a busy bit and reads the reply once it drops. The serial clock is the system clock divided by a parameter, in SPI mode 0 with the most significant bit first.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, busy reads 0, all chip selects are high, sclk is low, and every register and buffer byte reads 0.
- R2: Byte registers read back what was written: command byte at 0x00, chip-select number in bits [1:0] of 0x1D, send length at 0x48, receive length at 0x4B, and buffer entry i at 0x80+i for i below FIFO_DEPTH. The trigger byte 0x02 always reads 0.
- R3: Writing 1 to bit 0 of 0x02 starts a command. The command sends the command byte, then send-length bytes taken from the buffer at the pointer in ascending order, MSB first, for 8*(1+send+receive) rising sclk edges in total.
- R4: During the receive phase, miso is sampled on each rising sclk edge, MSB first. Each byte is stored at the pointer, which keeps climbing, and mosi stays 0. Nothing is captured during the command-byte or send phases.
- R5: While a command runs, only the chip select chosen by bits [1:0] of 0x1D is low, and it stays low on every cycle in which sclk is high. At all other times every chip select is high.
- R6: Bit 7 of 0x03 (busy) is set from the clock edge that takes the trigger until the last reply byte is stored, exactly 16*SCLK_HALF*(1+send+receive) cycles.
- R7: sclk idles low and has a period of 2*SCLK_HALF clocks. mosi does not change while sclk is high.
- R8: While busy, every register write is ignored, including a new trigger, a pointer reset, and changes to the command byte, lengths, chip-select number and buffer.
- R9: Writing 1 to bit 4 of 0x02 resets the buffer pointer to 0 and leaves the buffer contents unchanged. Without it, the next command continues from where the previous one stopped.
- R10: A buffer read by the engine past the last entry yields 0, and reply bytes past the last entry are dropped.
- R11: When one write sets both bit 4 and bit 0 of 0x02, the pointer reset takes effect before the command reads the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | 8 | Byte address for register and buffer access |
| regWrEn | input | 1 | Byte write strobe |
| regWrData | input | 8 | Byte write data |
| regRdData | output | 8 | Byte read data at regAddr (combinational) |
| sclk | output | 1 | SPI serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csN | output | NUM_CS | Active-low chip selects |

## Verification
Commands are run in several shapes, and each shape tells apart a different kind of fault:
- A command byte alone separates the end-of-command decision from the data phases.
- Send-only and receive-only commands check that each phase is entered or skipped on its own length.
- Mixed commands with and without a pointer reset, including a reset combined with the trigger, show whether reply bytes land right after the payload and whether the pointer carries over between commands.
- A command whose payload and reply run past the buffer end, followed by one that starts at the end, exposes bad saturation or wrap-around.
- Writes issued while busy show whether any of them leak into the running command or into the registers.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam int CNT_W = 8;

  localparam logic [7:0] ADDR_OPCODE = 8'h00;
  localparam logic [7:0] ADDR_TRIG   = 8'h02;
  localparam logic [7:0] ADDR_STATUS = 8'h03;
  localparam logic [7:0] ADDR_CSSEL  = 8'h1D;
  localparam logic [7:0] ADDR_TXLEN  = 8'h48;
  localparam logic [7:0] ADDR_RXLEN  = 8'h4B;
  localparam logic [7:0] ADDR_FIFO   = 8'h80;

  localparam int TRIG_EXEC_BIT = 0;
  localparam int TRIG_CLR_BIT  = 4;
  localparam int STAT_BUSY_BIT = 7;

  // Strobes from the sequencer to the datapath, valid for one clock.
  typedef struct packed {
    logic loadOpc;   // load the command byte into the shifter
    logic loadNext;  // load the buffer byte at the pointer, advance pointer
    logic shiftOut;  // shift the outgoing byte left by one
    logic sampleIn;  // shift miso into the shifter
    logic storeRx;   // write the shifter to the buffer, advance pointer
    logic txActive;  // level: command or send phase drives mosi
  } dpStrb_t;

endpackage

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
  import spi_cmd_pkg::*;
#(
  parameter int SCLK_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] txCount,
  input  logic [CNT_W-1:0] rxCount,
  output logic             busy,
  output logic             sclk,
  output dpStrb_t          strb
);

  localparam int DIV_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCLK_HALF - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_OPC, ST_TX, ST_RX} seqState_t;

  seqState_t        stateQ;
  logic [DIV_W-1:0] divQ;
  logic [2:0]       bitQ;
  logic [CNT_W-1:0] remTxQ;
  logic [CNT_W-1:0] remRxQ;
  logic             sclkQ;

  logic tick, riseEv, fallEv, byteEnd, inTx;

  always_comb begin
    tick    = (stateQ != ST_IDLE) && (divQ == DIV_LAST);
    riseEv  = tick && !sclkQ;
    fallEv  = tick && sclkQ;
    byteEnd = fallEv && (bitQ == 3'd7);
    inTx    = (stateQ == ST_OPC) || (stateQ == ST_TX);

    strb.loadOpc  = (stateQ == ST_IDLE) && startReq;
    strb.loadNext = byteEnd && inTx && (remTxQ != '0);
    strb.shiftOut = fallEv && inTx && (bitQ != 3'd7);
    strb.sampleIn = riseEv && (stateQ == ST_RX);
    strb.storeRx  = byteEnd && (stateQ == ST_RX);
    strb.txActive = inTx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      divQ   <= '0;
      bitQ   <= '0;
      remTxQ <= '0;
      remRxQ <= '0;
      sclkQ  <= 1'b0;
    end else if (stateQ == ST_IDLE) begin
      if (startReq) begin
        stateQ <= ST_OPC;
        remTxQ <= txCount;
        remRxQ <= rxCount;
        divQ   <= '0;
        bitQ   <= '0;
        sclkQ  <= 1'b0;
      end
    end else begin
      divQ <= tick ? '0 : divQ + 1'b1;
      if (tick)   sclkQ <= ~sclkQ;
      if (fallEv) bitQ  <= bitQ + 3'd1;
      if (byteEnd) begin
        if (stateQ == ST_RX) begin
          remRxQ <= remRxQ - 1'b1;
          if (remRxQ == CNT_W'(1)) stateQ <= ST_IDLE;
        end else if (remTxQ != '0) begin
          stateQ <= ST_TX;
          remTxQ <= remTxQ - 1'b1;
        end else if (remRxQ != '0) begin
          stateQ <= ST_RX;
        end else begin
          stateQ <= ST_IDLE;
        end
      end
    end
  end

  assign busy = (stateQ != ST_IDLE);
  assign sclk = sclkQ;

endmodule

// File: rtl/spi_cmd_dp.sv
module spi_cmd_dp
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 72,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              miso,
  output logic              mosi,
  output logic [NUM_CS-1:0] csN,
  input  logic              busy,
  input  dpStrb_t           strb,
  output logic              startReq,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);

  localparam int IDX_W = $clog2(FIFO_DEPTH);
  localparam int PTR_W = IDX_W + 1;
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam logic [8:0]       FIFO_LIM = 9'(FIFO_DEPTH);
  localparam logic [PTR_W-1:0] PTR_LIM  = PTR_W'(FIFO_DEPTH);

  logic [7:0]       fifoMem [FIFO_DEPTH];
  logic [7:0]       opcodeQ;
  logic [CNT_W-1:0] txCntQ, rxCntQ;
  logic [CS_W-1:0]  csSelQ;
  logic [PTR_W-1:0] ptrQ;
  logic [7:0]       shiftQ;

  logic             wrOk, clrReq, inFifo, ptrInRange;
  logic [7:0]       fifoOff;
  logic [IDX_W-1:0] swIdx, engIdx;
  logic [7:0]       engRdByte;

  always_comb begin
    wrOk       = regWrEn && !busy;
    startReq   = wrOk && (regAddr == ADDR_TRIG) && regWrData[TRIG_EXEC_BIT];
    clrReq     = wrOk && (regAddr == ADDR_TRIG) && regWrData[TRIG_CLR_BIT];
    fifoOff    = regAddr - ADDR_FIFO;
    inFifo     = (regAddr >= ADDR_FIFO) && ({1'b0, fifoOff} < FIFO_LIM);
    swIdx      = fifoOff[IDX_W-1:0];
    ptrInRange = ptrQ < PTR_LIM;
    engIdx     = ptrQ[IDX_W-1:0];
    engRdByte  = ptrInRange ? fifoMem[engIdx] : 8'h00;
  end

  // Configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opcodeQ <= '0;
      txCntQ  <= '0;
      rxCntQ  <= '0;
      csSelQ  <= '0;
    end else if (wrOk) begin
      case (regAddr)
        ADDR_OPCODE: opcodeQ <= regWrData;
        ADDR_TXLEN:  txCntQ  <= regWrData;
        ADDR_RXLEN:  rxCntQ  <= regWrData;
        ADDR_CSSEL:  csSelQ  <= regWrData[CS_W-1:0];
        default: ;
      endcase
    end
  end

  // Buffer pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (clrReq) begin
      ptrQ <= '0;
    end else if ((strb.loadNext || strb.storeRx) && ptrInRange) begin
      ptrQ <= ptrQ + 1'b1;
    end
  end

  // Shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (strb.loadOpc) begin
      shiftQ <= opcodeQ;
    end else if (strb.loadNext) begin
      shiftQ <= engRdByte;
    end else if (strb.shiftOut) begin
      shiftQ <= {shiftQ[6:0], 1'b0};
    end else if (strb.sampleIn) begin
      shiftQ <= {shiftQ[6:0], miso};
    end
  end

  // Shared byte buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < FIFO_DEPTH; i++) fifoMem[i] <= '0;
    end else if (strb.storeRx && ptrInRange) begin
      fifoMem[engIdx] <= shiftQ;
    end else if (wrOk && inFifo) begin
      fifoMem[swIdx] <= regWrData;
    end
  end

  always_comb begin
    regRdData = '0;
    if (inFifo) begin
      regRdData = fifoMem[swIdx];
    end else begin
      case (regAddr)
        ADDR_OPCODE: regRdData = opcodeQ;
        ADDR_STATUS: regRdData = {busy, 7'b0};
        ADDR_CSSEL:  regRdData = 8'(csSelQ);
        ADDR_TXLEN:  regRdData = txCntQ;
        ADDR_RXLEN:  regRdData = rxCntQ;
        default:     regRdData = '0;
      endcase
    end
  end

  assign mosi    = strb.txActive & shiftQ[7];
  assign txCount = txCntQ;
  assign rxCount = rxCntQ;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign csN[g] = !(busy && (csSelQ == CS_W'(g)));
  end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int FIFO_DEPTH = 72,
  parameter int SCLK_HALF  = 2,
  parameter int NUM_CS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_CS-1:0] csN
);

  logic             busyW;
  logic             startW;
  logic [CNT_W-1:0] txCntW;
  logic [CNT_W-1:0] rxCntW;
  dpStrb_t          strbW;

  spi_cmd_ctrl #(
    .SCLK_HALF(SCLK_HALF)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startW),
    .txCount  (txCntW),
    .rxCount  (rxCntW),
    .busy     (busyW),
    .sclk     (sclk),
    .strb     (strbW)
  );

  spi_cmd_dp #(
    .FIFO_DEPTH(FIFO_DEPTH),
    .NUM_CS    (NUM_CS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .miso      (miso),
    .mosi      (mosi),
    .csN       (csN),
    .busy      (busyW),
    .strb      (strbW),
    .startReq  (startW),
    .txCount   (txCntW),
    .rxCount   (rxCntW)
  );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              sclk,
  input logic              mosi,
  input logic [NUM_CS-1:0] csN,
  input logic              regWrEn,
  input logic [7:0]        regAddr,
  input logic [7:0]        regWrData
);

  // R5: never more than one device selected
  a_r5_single_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R5: a device is selected whenever the serial clock is high
  a_r5_cs_under_sclk: assert property (@(posedge clk) disable iff (!rstN)
    sclk |-> !(&csN));

  // R5, R8: the selected device does not change mid-command
  a_r5_cs_steady: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(csN));

  // R7: serial clock rests low between commands
  a_r7_sclk_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R7: data out is steady across a rising serial clock
  a_r7_mosi_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclk) |-> $stable(mosi));

  // R3, R6: an accepted trigger starts the command on the next cycle
  a_r6_trigger_starts: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && (regAddr == 8'h02) && regWrData[0] && !busy) |=> busy);

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
  .NUM_CS(NUM_CS)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busyW),
  .sclk      (sclk),
  .mosi      (mosi),
  .csN       (csN),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData)
);

// File: tb/spi_cmd_engine_tb.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb;
  localparam int DEPTH = 72;
  localparam int HALF  = 2;
  localparam int NCS   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic regWrEn = 1'b0;
  wire  [7:0] regRdData;
  wire  sclk, mosi;
  logic miso;
  wire  [NCS-1:0] csN;

  spi_cmd_engine #(.FIFO_DEPTH(DEPTH), .SCLK_HALF(HALF), .NUM_CS(NCS)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sclk(sclk), .mosi(mosi),
    .miso(miso), .csN(csN));

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Slave-side model state
  int riseCnt = 0;
  int csLowCyc = 0;
  int cyc = 0;
  int lastRise = 0;
  logic prevSclk = 1'b0;
  logic prevMosi = 1'b0;
  bit mosiLog[$];
  int riseBase = 0;
  int expSel = 0;
  bit respBits [0:2047];

  always_comb begin
    if (riseCnt >= riseBase && (riseCnt - riseBase) < 2048)
      miso = respBits[riseCnt - riseBase];
    else
      miso = 1'b1;
  end

  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (csN != {NCS{1'b1}}) begin
        csLowCyc++;
        chk(csN == ~(4'(1) << expSel), "R5 chosen select", int'(csN), int'(~(4'(1) << expSel)));
      end
      if (sclk) chk(csN != {NCS{1'b1}}, "R5 select low under sclk", int'(csN), 0);
      if (sclk && !prevSclk) begin
        if (riseCnt > riseBase)
          chk(cyc - lastRise == 2 * HALF, "R7 sclk period", cyc - lastRise, 2 * HALF);
        mosiLog.push_back(mosi);
        riseCnt++;
        lastRise = cyc;
      end
      if (sclk && prevSclk) chk(mosi == prevMosi, "R7 mosi held while sclk high", mosi, prevMosi);
      prevSclk = sclk;
      prevMosi = mosi;
    end
  end

  logic [7:0] mdl [DEPTH];
  int mPtr = 0;

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    regAddr = a; regWrEn = 1'b0;
    #1 v = regRdData;
  endtask

  task automatic checkFifo(input string tag);
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h80 + 8'(i), v);
      chk(v == mdl[i], tag, v, mdl[i]);
    end
  endtask

  // clrMode: 0 none, 1 separate reset write, 2 reset combined with trigger
  task automatic runCmd(input logic [7:0] op, input int txN, input int rxN, input int sel,
                        input int clrMode, input bit meddle, input string tag);
    logic [7:0] expBytes[$];
    logic [7:0] v, got, resp;
    int base, csBase, nBytes, polls, bitPos;
    wr(8'h00, op); wr(8'h48, 8'(txN)); wr(8'h4B, 8'(rxN)); wr(8'h1D, 8'(sel));
    expSel = sel;
    if (clrMode != 0) mPtr = 0;
    expBytes.push_back(op);
    for (int i = 0; i < txN; i++) begin
      expBytes.push_back(mPtr < DEPTH ? mdl[mPtr] : 8'h00);
      if (mPtr < DEPTH) mPtr++;
    end
    for (int i = 0; i < (1 + txN) * 8; i++) respBits[i] = 1'b1;
    bitPos = (1 + txN) * 8;
    for (int i = 0; i < rxN; i++) begin
      resp = 8'hA5 ^ 8'(i * 37) ^ op;
      for (int k = 7; k >= 0; k--) begin respBits[bitPos] = resp[k]; bitPos++; end
      expBytes.push_back(8'h00);
      if (mPtr < DEPTH) begin mdl[mPtr] = resp; mPtr++; end
    end
    riseBase = riseCnt; base = mosiLog.size(); csBase = csLowCyc;
    if (clrMode == 1) begin wr(8'h02, 8'h10); wr(8'h02, 8'h01); end
    else if (clrMode == 2) wr(8'h02, 8'h11);
    else wr(8'h02, 8'h01);
    if (meddle) begin
      wr(8'h48, 8'h33); wr(8'h80, 8'h5A); wr(8'h00, 8'hEE);
      wr(8'h1D, 8'h03); wr(8'h02, 8'h11); wr(8'h4B, 8'h07);
    end
    rd(8'h03, v);
    chk(v[7] == 1'b1, "R6 busy bit set", v, 8'h80);
    polls = 0;
    while (v[7] && polls < 100000) begin rd(8'h03, v); polls++; end
    repeat (2) @(negedge clk);
    nBytes = 1 + txN + rxN;
    chk(csLowCyc - csBase == nBytes * 16 * HALF, "R6 busy span", csLowCyc - csBase, nBytes * 16 * HALF);
    chk(riseCnt - riseBase == nBytes * 8, "R3 sclk edges", riseCnt - riseBase, nBytes * 8);
    if (mosiLog.size() >= base + nBytes * 8) begin
      for (int b = 0; b < nBytes; b++) begin
        got = 8'h00;
        for (int k = 0; k < 8; k++) got = {got[6:0], mosiLog[base + b * 8 + k]};
        if (b <= txN) chk(got == expBytes[b], "R3 sent byte", got, expBytes[b]);
        else chk(got == 8'h00, "R4 mosi low on receive", got, 8'h00);
      end
    end
    checkFifo(tag);
  endtask

  initial begin
    logic [7:0] v;
    for (int i = 0; i < DEPTH; i++) mdl[i] = 8'h00;
    repeat (5) @(negedge clk);
    chk(csN == {NCS{1'b1}}, "R1 selects high in reset", csN, 4'hF);
    rstN = 1'b1;
    @(negedge clk);
    chk(csN == {NCS{1'b1}} && sclk == 1'b0, "R1 pins idle", {csN, sclk}, 5'h1E);
    rd(8'h03, v); chk(v == 8'h00, "R1 busy clear", v, 0);
    rd(8'h00, v); chk(v == 8'h00, "R1 command byte", v, 0);
    rd(8'h48, v); chk(v == 8'h00, "R1 send length", v, 0);
    checkFifo("R1 buffer cleared");

    // R2 register and buffer access
    for (int i = 0; i < DEPTH; i++) begin
      mdl[i] = 8'(i * 13 + 7);
      wr(8'h80 + 8'(i), mdl[i]);
    end
    checkFifo("R2 buffer readback");
    wr(8'h00, 8'h3C); rd(8'h00, v); chk(v == 8'h3C, "R2 command byte", v, 8'h3C);
    wr(8'h48, 8'h21); rd(8'h48, v); chk(v == 8'h21, "R2 send length", v, 8'h21);
    wr(8'h4B, 8'h12); rd(8'h4B, v); chk(v == 8'h12, "R2 receive length", v, 8'h12);
    wr(8'h1D, 8'hFE); rd(8'h1D, v); chk(v == 8'h02, "R2 select field", v, 8'h02);
    rd(8'h02, v); chk(v == 8'h00, "R2 trigger reads zero", v, 0);

    runCmd(8'h06, 0, 0, 2, 1, 1'b0, "R3 command byte only");
    runCmd(8'h9F, 0, 3, 0, 1, 1'b0, "R4 receive only");
    runCmd(8'h02, 3, 0, 1, 1, 1'b0, "R3 send only");
    runCmd(8'h0B, 2, 2, 2, 0, 1'b0, "R9 pointer carries over");
    runCmd(8'h03, 1, 2, 3, 2, 1'b0, "R11 combined reset and trigger");
    runCmd(8'h05, 4, 2, 1, 1, 1'b1, "R8 writes while busy");
    rd(8'h00, v); chk(v == 8'h05, "R8 command byte kept", v, 8'h05);
    rd(8'h48, v); chk(v == 8'h04, "R8 send length kept", v, 8'h04);
    rd(8'h4B, v); chk(v == 8'h02, "R8 receive length kept", v, 8'h02);
    rd(8'h1D, v); chk(v == 8'h01, "R8 select kept", v, 8'h01);
    wr(8'h02, 8'h10);
    mPtr = 0;
    checkFifo("R9 reset keeps data");
    runCmd(8'hAB, 70, 5, 0, 1, 1'b0, "R10 reply past buffer end");
    runCmd(8'h4D, 2, 1, 3, 0, 1'b0, "R10 start past buffer end");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule